// File: doc/BRIEF.md
# Omega Network with Drop-on-Conflict Routing

This block joins N requesting sources to N target ports through log2(N) columns of two-by-two switching elements. Each column holds N/2 elements, and the lines are re-ordered by a perfect shuffle in front of every column. A request is a valid flag, a destination port number and a data word. Each column reads one bit of the destination and sets its element to pass the request straight through or to cross it over. After the last column, a request sits on the output line whose index equals its destination.

The whole path through the columns is combinational. Only the delivery side is registered: output valid, data and originating source index. The same register edge returns a one-cycle acknowledge to every source whose request got through. It returns a one-cycle drop pulse to every source whose request lost a contest inside an element. A dropped source may present the same request again on any later cycle. Nothing is held inside the network between cycles. N must be a power of two and defaults to 8.

Top module: `omega_net`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, out_valid, ack and drop are all zero.
- R2: A request presented alone with destination d on cycle t appears on port d on cycle t+1. out_valid[d] is high, out_data holds its word and out_src holds its source index.
- R3: A source whose request is delivered sees ack high for exactly the cycle on which out_valid shows it. ack and out_valid have equal population counts, and ack is low on a cycle that follows an idle input.
- R4: The identity permutation and the shift-by-one permutation (source i to port (i+1) mod N) deliver all N requests on the same cycle with no drop.
- R5: When both inputs of an element need the same output, the request on the element's even-numbered line passes. For N=8, sources 0 and 4 both sent to port 0 give ack=0x01 and drop=0x10.
- R6: A source that loses a contest gets drop high for one cycle, on the cycle that delivery would have occurred, and gets no ack on that cycle.
- R7: Every valid request gets exactly one of ack or drop on the next cycle, and a source with no valid request gets neither.
- R8: When all N sources target one port, exactly one request is delivered. For N=8 and port 2, source 0 wins, giving ack=0x01 and drop=0xFE.
- R9: A dropped request presented again with no competitor is delivered and acknowledged.
- R10: Before column k, line i moves to line rotate-left(i) over log2(N) bits. Column k pairs lines 2p and 2p+1 and reads destination bit log2(N)-1-k: a 0 selects output 2p and a 1 selects output 2p+1. Arbitrary request patterns match a model built on this rule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | N | Request valid, one bit per source |
| in_dest | input | N*log2(N) | Destination port per source, source i in slice i |
| in_data | input | N*DW | Data word per source |
| out_valid | output | N | Delivery valid per output port, registered |
| out_data | output | N*DW | Delivered data per port |
| out_src | output | N*log2(N) | Originating source index per port |
| ack | output | N | One-cycle delivery acknowledge per source |
| drop | output | N | One-cycle rejection pulse per source |

## Verification
Clocked properties check several rules on every cycle. Each column conserves requests: the requests it passes plus the ones it rejects equal the ones it received. Every request leaving a column sits on the line its selected destination bit calls for. ack and drop are never high together for one source. The count of acknowledges matches the count of deliveries. An ack or drop only follows a valid request from that source. The assertions cannot show which competitor wins a contest, that data and source index arrive on the right port, or that a retry succeeds. The bench scenarios cover these by comparing against hand-derived values and a column-by-column reference model.

// File: rtl/omega_pkg.sv
package omega_pkg;

  typedef enum logic {
    SW_STRAIGHT = 1'b0,
    SW_EXCHANGE = 1'b1
  } sw_mode_e;

  // perfect shuffle: rotate a line index left by one over nbits
  function automatic int shuffle_line(input int idx, input int nbits);
    int top_bit;
    top_bit = (idx >> (nbits - 1)) & 1;
    return ((idx << 1) & ((1 << nbits) - 1)) | top_bit;
  endfunction

endpackage

// File: rtl/omega_switch.sv
module omega_switch
  import omega_pkg::*;
#(
  parameter int AW      = 3,
  parameter int DW      = 8,
  parameter int SEL_BIT = 2
) (
  input  logic          a_vld,
  input  logic [AW-1:0] a_dst,
  input  logic [AW-1:0] a_src,
  input  logic [DW-1:0] a_dat,
  input  logic          b_vld,
  input  logic [AW-1:0] b_dst,
  input  logic [AW-1:0] b_src,
  input  logic [DW-1:0] b_dat,
  output logic          u_vld,
  output logic [AW-1:0] u_dst,
  output logic [AW-1:0] u_src,
  output logic [DW-1:0] u_dat,
  output logic          l_vld,
  output logic [AW-1:0] l_dst,
  output logic [AW-1:0] l_src,
  output logic [DW-1:0] l_dat,
  output logic          rej_vld,
  output logic [AW-1:0] rej_src
);

  sw_mode_e mode;
  logic     a_bit;
  logic     b_bit;
  logic     clash;

  assign a_bit = a_dst[SEL_BIT];
  assign b_bit = b_dst[SEL_BIT];
  assign clash = a_vld & b_vld & (a_bit == b_bit);

  // the even line (a) sets the element when it carries a request
  always_comb begin
    if (a_vld)      mode = a_bit ? SW_EXCHANGE : SW_STRAIGHT;
    else if (b_vld) mode = b_bit ? SW_STRAIGHT : SW_EXCHANGE;
    else            mode = SW_STRAIGHT;
  end

  always_comb begin
    if (mode == SW_STRAIGHT) begin
      u_vld = a_vld;          u_dst = a_dst; u_src = a_src; u_dat = a_dat;
      l_vld = b_vld & ~clash; l_dst = b_dst; l_src = b_src; l_dat = b_dat;
    end else begin
      u_vld = b_vld & ~clash; u_dst = b_dst; u_src = b_src; u_dat = b_dat;
      l_vld = a_vld;          l_dst = a_dst; l_src = a_src; l_dat = a_dat;
    end
  end

  assign rej_vld = clash;
  assign rej_src = b_src;

endmodule

// File: rtl/omega_stage.sv
module omega_stage
  import omega_pkg::*;
#(
  parameter int N     = 8,
  parameter int AW    = 3,
  parameter int DW    = 8,
  parameter int STAGE = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    in_vld,
  input  logic [N*AW-1:0] in_dst,
  input  logic [N*AW-1:0] in_src,
  input  logic [N*DW-1:0] in_dat,
  output logic [N-1:0]    out_vld,
  output logic [N*AW-1:0] out_dst,
  output logic [N*AW-1:0] out_src,
  output logic [N*DW-1:0] out_dat,
  output logic [N-1:0]    drop_vec
);

  localparam int SEL_BIT = AW - 1 - STAGE;
  localparam int NSW     = N / 2;

  logic          sh_vld [N];
  logic [AW-1:0] sh_dst [N];
  logic [AW-1:0] sh_src [N];
  logic [DW-1:0] sh_dat [N];
  logic          sw_vld [N];
  logic [AW-1:0] sw_dst [N];
  logic [AW-1:0] sw_src [N];
  logic [DW-1:0] sw_dat [N];
  logic          rej_vld [NSW];
  logic [AW-1:0] rej_src [NSW];

  // shuffle wiring into the column
  for (genvar i = 0; i < N; i++) begin : g_shuffle
    localparam int J = shuffle_line(i, AW);
    assign sh_vld[J] = in_vld[i];
    assign sh_dst[J] = in_dst[i*AW +: AW];
    assign sh_src[J] = in_src[i*AW +: AW];
    assign sh_dat[J] = in_dat[i*DW +: DW];
  end

  for (genvar p = 0; p < NSW; p++) begin : g_elem
    omega_switch #(.AW(AW), .DW(DW), .SEL_BIT(SEL_BIT)) sw_i (
      .a_vld  (sh_vld[2*p]),   .a_dst(sh_dst[2*p]),   .a_src(sh_src[2*p]),   .a_dat(sh_dat[2*p]),
      .b_vld  (sh_vld[2*p+1]), .b_dst(sh_dst[2*p+1]), .b_src(sh_src[2*p+1]), .b_dat(sh_dat[2*p+1]),
      .u_vld  (sw_vld[2*p]),   .u_dst(sw_dst[2*p]),   .u_src(sw_src[2*p]),   .u_dat(sw_dat[2*p]),
      .l_vld  (sw_vld[2*p+1]), .l_dst(sw_dst[2*p+1]), .l_src(sw_src[2*p+1]), .l_dat(sw_dat[2*p+1]),
      .rej_vld(rej_vld[p]),
      .rej_src(rej_src[p])
    );
  end

  for (genvar j = 0; j < N; j++) begin : g_pack
    assign out_vld[j]           = sw_vld[j];
    assign out_dst[j*AW +: AW]  = sw_dst[j];
    assign out_src[j*AW +: AW]  = sw_src[j];
    assign out_dat[j*DW +: DW]  = sw_dat[j];
  end

  always_comb begin
    drop_vec = '0;
    for (int p = 0; p < NSW; p++) begin
      if (rej_vld[p]) drop_vec[rej_src[p]] = 1'b1;
    end
  end

  // R7: a column neither creates nor loses requests
  p_conserve_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(out_vld) + $countones(drop_vec)) == $countones(in_vld));

  // R10: each delivered line matches the destination bit of this column
  for (genvar j = 0; j < N; j++) begin : g_chk
    p_route_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld[j] |-> (out_dst[j*AW + SEL_BIT] == 1'(j % 2)));
  end

endmodule

// File: rtl/omega_net.sv
module omega_net #(
  parameter int N  = 8,
  parameter int DW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N-1:0]             in_valid,
  input  logic [N*$clog2(N)-1:0]   in_dest,
  input  logic [N*DW-1:0]          in_data,
  output logic [N-1:0]             out_valid,
  output logic [N*DW-1:0]          out_data,
  output logic [N*$clog2(N)-1:0]   out_src,
  output logic [N-1:0]             ack,
  output logic [N-1:0]             drop
);

  localparam int AW = $clog2(N);
  localparam int NS = AW;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  // column chain
  logic [N-1:0]    lv [NS+1];
  logic [N*AW-1:0] ld [NS+1];
  logic [N*AW-1:0] ls [NS+1];
  logic [N*DW-1:0] lt [NS+1];
  logic [N-1:0]    dv [NS];

  assign lv[0] = in_valid;
  assign ld[0] = in_dest;
  assign lt[0] = in_data;
  for (genvar i = 0; i < N; i++) begin : g_srcid
    assign ls[0][i*AW +: AW] = AW'(i);
  end

  for (genvar k = 0; k < NS; k++) begin : g_col
    omega_stage #(.N(N), .AW(AW), .DW(DW), .STAGE(k)) stage_i (
      .clk     (clk),
      .rst_n   (rst_q_n),
      .in_vld  (lv[k]),
      .in_dst  (ld[k]),
      .in_src  (ls[k]),
      .in_dat  (lt[k]),
      .out_vld (lv[k+1]),
      .out_dst (ld[k+1]),
      .out_src (ls[k+1]),
      .out_dat (lt[k+1]),
      .drop_vec(dv[k])
    );
  end

  // next state
  logic [N-1:0] ack_nxt;
  logic [N-1:0] drop_nxt;

  always_comb begin
    ack_nxt  = '0;
    drop_nxt = '0;
    for (int k = 0; k < NS; k++) drop_nxt = drop_nxt | dv[k];
    for (int j = 0; j < N; j++) begin
      if (lv[NS][j]) ack_nxt[ls[NS][j*AW +: AW]] = 1'b1;
    end
  end

  // registers
  logic [N-1:0]    vld_q;
  logic [N-1:0]    ack_q;
  logic [N-1:0]    drop_q;
  logic [N*DW-1:0] dat_q;
  logic [N*AW-1:0] src_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      vld_q  <= '0;
      ack_q  <= '0;
      drop_q <= '0;
    end else begin
      vld_q  <= lv[NS];
      ack_q  <= ack_nxt;
      drop_q <= drop_nxt;
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_port
    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n) begin
        dat_q[j*DW +: DW] <= '0;
        src_q[j*AW +: AW] <= '0;
      end else if (lv[NS][j]) begin
        dat_q[j*DW +: DW] <= lt[NS][j*DW +: DW];
        src_q[j*AW +: AW] <= ls[NS][j*AW +: AW];
      end
    end
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;
  assign out_src   = src_q;
  assign ack       = ack_q;
  assign drop      = drop_q;

  // R7: a source never sees both outcomes at once
  p_ack_drop_excl_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ack_q & drop_q) == '0);

  // R3: one acknowledge per delivery
  p_ack_eq_deliv_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    $countones(ack_q) == $countones(vld_q));

  for (genvar i = 0; i < N; i++) begin : g_src_chk
    // R3: ack only follows a request from that source
    p_ack_had_req_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
      ack_q[i] |-> $past(in_valid[i]));
    // R6: drop only follows a request from that source
    p_drop_had_req_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
      drop_q[i] |-> $past(in_valid[i]));
  end

endmodule

// File: tb/omega_net_tb_top.sv
module omega_net_tb_top;

  localparam int N  = 8;
  localparam int AW = 3;
  localparam int DW = 8;

  typedef struct packed {
    logic [N-1:0]    vld;
    logic [N-1:0]    ack;
    logic [N-1:0]    drop;
    logic [N*DW-1:0] dat;
    logic [N*AW-1:0] src;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    in_valid;
  logic [N*AW-1:0] in_dest;
  logic [N*DW-1:0] in_data;
  logic [N-1:0]    out_valid;
  logic [N*DW-1:0] out_data;
  logic [N*AW-1:0] out_src;
  logic [N-1:0]    ack;
  logic [N-1:0]    drop;

  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 1'b0;
  exp_t  exp_q [$];
  string tag_q [$];

  always #10 clk = ~clk;

  omega_net #(.N(N), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_dest(in_dest), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_src(out_src),
    .ack(ack), .drop(drop)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // column-by-column reference built from R5 and R10
  function automatic exp_t model(input logic [N-1:0] v, input logic [N*AW-1:0] d,
                                 input logic [N*DW-1:0] x);
    exp_t e;
    logic lv[N]; logic nv[N];
    int ld[N]; int ls[N]; int nd[N]; int ns[N];
    logic [DW-1:0] lx[N]; logic [DW-1:0] nx[N];
    e = '0;
    for (int i = 0; i < N; i++) begin
      lv[i] = v[i]; ld[i] = int'(d[i*AW +: AW]); ls[i] = i; lx[i] = x[i*DW +: DW];
    end
    for (int s = 0; s < AW; s++) begin
      for (int i = 0; i < N; i++) begin
        int j;
        j = ((i << 1) & (N - 1)) | (i >> (AW - 1));
        nv[j] = lv[i]; nd[j] = ld[i]; ns[j] = ls[i]; nx[j] = lx[i];
      end
      for (int i = 0; i < N; i++) lv[i] = 1'b0;
      for (int p = 0; p < N / 2; p++) begin
        int a; int b; int ba; int bb;
        a = 2 * p; b = 2 * p + 1;
        ba = (nd[a] >> (AW - 1 - s)) & 1;
        bb = (nd[b] >> (AW - 1 - s)) & 1;
        if (nv[a]) begin
          lv[2*p+ba] = 1'b1; ld[2*p+ba] = nd[a]; ls[2*p+ba] = ns[a]; lx[2*p+ba] = nx[a];
        end
        if (nv[b]) begin
          if (nv[a] && ba == bb) e.drop[ns[b]] = 1'b1;
          else begin
            lv[2*p+bb] = 1'b1; ld[2*p+bb] = nd[b]; ls[2*p+bb] = ns[b]; lx[2*p+bb] = nx[b];
          end
        end
      end
    end
    for (int j = 0; j < N; j++) begin
      if (lv[j]) begin
        e.vld[j] = 1'b1;
        e.ack[ls[j]] = 1'b1;
        e.dat[j*DW +: DW] = lx[j];
        e.src[j*AW +: AW] = AW'(ls[j]);
      end
    end
    return e;
  endfunction

  // driver: apply one cycle of requests and queue the expectation
  task automatic drive(input logic [N-1:0] v, input logic [N*AW-1:0] d,
                       input logic [N*DW-1:0] x, input exp_t e, input string tag);
    @(negedge clk);
    in_valid = v; in_dest = d; in_data = x;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic send(input logic [N-1:0] v, input logic [N*AW-1:0] d,
                      input logic [N*DW-1:0] x, input string tag);
    drive(v, d, x, model(v, d, x), tag);
  endtask

  // hand-derived outcome overrides the model for valid/ack/drop
  task automatic send_hand(input logic [N-1:0] v, input logic [N*AW-1:0] d,
                           input logic [N*DW-1:0] x, input logic [N-1:0] ev,
                           input logic [N-1:0] ea, input logic [N-1:0] ed, input string tag);
    exp_t e;
    e = model(v, d, x);
    e.vld = ev; e.ack = ea; e.drop = ed;
    drive(v, d, x, e, tag);
  endtask

  task automatic idle(input string tag);
    send('0, '0, '0, tag);
  endtask

  // monitor: compare registered outputs one cycle after each driven cycle
  initial begin
    forever begin
      @(posedge clk);
      #4;
      if (exp_q.size() > 0) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({t, " out_valid"}, 64'(out_valid), 64'(e.vld));
        chk({t, " ack"},       64'(ack),       64'(e.ack));
        chk({t, " drop"},      64'(drop),      64'(e.drop));
        for (int j = 0; j < N; j++) begin
          if (e.vld[j]) begin
            chk({t, " data"}, 64'(out_data[j*DW +: DW]), 64'(e.dat[j*DW +: DW]));
            chk({t, " src"},  64'(out_src[j*AW +: AW]),  64'(e.src[j*AW +: AW]));
          end
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [N*AW-1:0] d;
    logic [N*DW-1:0] x;
    logic [31:0]     lfsr;
    rst_n = 1'b0; in_valid = '0; in_dest = '0; in_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 64'(out_valid), 64'h0);
    chk("R1 ack in reset",   64'(ack),       64'h0);
    chk("R1 drop in reset",  64'(drop),      64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 valid after reset", 64'(out_valid), 64'h0);
    chk("R1 ack after reset",   64'(ack),       64'h0);

    // R2: each source alone to a distinct port
    for (int s = 0; s < N; s++) begin
      int dst;
      dst = (s * 3 + 1) % N;
      d = '0; x = '0;
      d[s*AW +: AW] = AW'(dst);
      x[s*DW +: DW] = DW'(8'hA0 + s);
      send_hand(N'(1) << s, d, x, N'(1) << dst, N'(1) << s, '0, "R2");
    end
    idle("R3 idle clears ack");

    // R4: identity and shift-by-one permutations
    for (int i = 0; i < N; i++) begin
      d[i*AW +: AW] = AW'(i); x[i*DW +: DW] = DW'(8'h10 + i);
    end
    send_hand('1, d, x, '1, '1, '0, "R4 identity");
    for (int i = 0; i < N; i++) begin
      d[i*AW +: AW] = AW'((i + 1) % N); x[i*DW +: DW] = DW'(8'h30 + i);
    end
    send_hand('1, d, x, '1, '1, '0, "R4 shift");
    idle("R3 idle after burst");

    // R5/R6: sources 0 and 4 both to port 0; R9 retry of source 4
    d = '0; x = '0;
    x[0*DW +: DW] = 8'h55; x[4*DW +: DW] = 8'h66;
    send_hand(8'h11, d, x, 8'h01, 8'h01, 8'h10, "R5 conflict");
    send_hand(8'h10, d, x, 8'h01, 8'h10, 8'h00, "R9 retry");
    idle("R6 drop lasts one cycle");

    // R8: every source to port 2
    for (int i = 0; i < N; i++) begin
      d[i*AW +: AW] = AW'(2); x[i*DW +: DW] = DW'(8'hC0 + i);
    end
    send_hand('1, d, x, 8'h04, 8'h01, 8'hFE, "R8 hot spot");

    // R7/R10: pseudo-random patterns against the reference
    lfsr = 32'h1ACE_B00C;
    for (int it = 0; it < 60; it++) begin
      logic [N-1:0] v;
      for (int i = 0; i < N; i++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        d[i*AW +: AW] = lfsr[AW-1:0];
        x[i*DW +: DW] = lfsr[15:8];
      end
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      v = lfsr[N+3:4];
      send(v, d, x, (it % 2 == 0) ? "R10 random" : "R7 random");
    end
    idle("R7 idle");
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule